// File: doc/BRIEF.md
# Signed Booth Multiply-Accumulate with Redundant Accumulator

This block multiplies two 8-bit two's-complement operands and adds the product into a running total on every accepted cycle. The multiplier operand is recoded into four radix-4 signed digits. Each digit selects 0, ±Y or ±2Y. A negative selection is formed by inverting the bits, and a separate +1 correction bit finishes the two's-complement negation. Sign extension is not replicated across each row: each row's top bit is flipped and a single precomputed constant is added instead.

The running total is never stored as a plain binary number. A carry-save tree reduces the four rows, the correction vector and the previous cycle's sum and carry vectors. The tree's two lowest bits are then resolved by a small lookahead adder. Its carry-out is stored as a single bit that goes back into the tree on the next cycle. Only a separate output stage, outside the feedback loop, resolves the redundant pair into a 20-bit result: 16 product bits plus 4 guard bits.

A clear request either restarts the total from the current product, when it comes with a valid sample, or zeroes the total, when it comes alone. The pipeline has three registered stages: digit and row generation, carry-save accumulation, and final addition. A new sample may be offered on every clock.

Top module: `booth_mac_csa`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_acc` is 0, and the accumulated total is zero, so the first valid sample without clear yields just its product.
- R2: Each cycle with `in_valid` high adds the signed product `in_x * in_y` to the total. The result reported for that sample is the new total, modulo 2^20, as a two's-complement value.
- R3: `out_valid` rises exactly three clock edges after the edge that samples `in_valid` high, and `out_acc` carries that sample's total in the same cycle. Samples on consecutive cycles each produce one result on consecutive cycles.
- R4: A cycle with `in_valid` low and `in_clear` low leaves the total unchanged and produces no result: `out_valid` stays 0 and `out_acc` holds its last value.
- R5: A sample with `in_valid` and `in_clear` both high discards the previous total, and its result is exactly the sign-extended product of that sample.
- R6: `in_clear` high with `in_valid` low zeroes the total without producing a result. The next valid sample reports only its own product.
- R7: The extreme operand pairs are exact: -128 × -128 gives 16384, -128 × 127 and 127 × -128 give -16256, and 127 × 127 gives 16129.
- R8: The 20-bit total absorbs 16 accumulations of the largest product (-128 × -128) without overflow (262144). Beyond that it wraps with two's-complement rules: after 32 such products `out_acc` reads 20'h80000.
- R9: A sample with either operand equal to 0 still produces a result, and that result equals the previous total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample qualifier for `in_x`/`in_y` |
| in_clear | input | 1 | Restart (with valid) or zero (alone) the running total |
| in_x | input | 8 | Multiplier operand, two's complement, Booth-recoded |
| in_y | input | 8 | Multiplicand operand, two's complement |
| out_valid | output | 1 | Result qualifier |
| out_acc | output | 20 | Running total after the matching sample, two's complement |

## Verification
Every result is due three rising edges after the edge that captures its sample. When the bench drives a sample, it stamps the sample with the cycle number at which the matching result must appear. A monitor on the falling edge takes the expected value off the head of a list in that cycle only. A missing `out_valid`, an early or extra result, or a wrong value is each a failure. Idle and clear-only cycles push no expectation, so any result they cause shows up as unexpected, and `out_acc` is also compared against its previous value on each idle cycle.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int OPW   = 8;               // operand width
    localparam int GUARD = 4;               // guard bits above the full product
    localparam int ACCW  = 2 * OPW + GUARD; // redundant accumulator width
    localparam int LOWW  = 2;               // bits resolved early inside the loop
    localparam int UPW   = ACCW - LOWW;     // bits left for the final adder
    localparam int NPP   = OPW / 2;         // radix-4 digits / partial-product rows
    localparam int PPW   = OPW + 1;         // row width (holds 2Y)
    localparam int LAT   = 3;               // pipeline stages, input to result

    typedef logic [ACCW-1:0] acc_t;

    typedef enum logic [2:0] {
        DIG_ZERO = 3'd0,
        DIG_P1   = 3'd1,
        DIG_P2   = 3'd2,
        DIG_M1   = 3'd3,
        DIG_M2   = 3'd4
    } digit_e;

    typedef struct packed {
        logic [PPW-1:0] bits; // ones'-complement multiple
        logic           neg;  // +1 correction at the row's lsb
    } pp_row_t;

    typedef struct packed {
        acc_t sum;
        acc_t cry;
    } csa_t;

    function automatic digit_e recode(input logic [2:0] trip);
        case (trip)
            3'b001, 3'b010: recode = DIG_P1;
            3'b011:         recode = DIG_P2;
            3'b100:         recode = DIG_M2;
            3'b101, 3'b110: recode = DIG_M1;
            default:        recode = DIG_ZERO;
        endcase
    endfunction

    function automatic pp_row_t make_row(input digit_e dig, input logic [OPW-1:0] y);
        logic [PPW-1:0] mult;
        logic           neg;
        case (dig)
            DIG_P1, DIG_M1: mult = {y[OPW-1], y};
            DIG_P2, DIG_M2: mult = {y, 1'b0};
            default:        mult = '0;
        endcase
        neg = (dig == DIG_M1) || (dig == DIG_M2);
        make_row.bits = neg ? ~mult : mult;
        make_row.neg  = neg;
    endfunction

    // 3:2 compressor across the whole accumulator width
    function automatic csa_t csa3(input acc_t a, input acc_t b, input acc_t c);
        csa3.sum = a ^ b ^ c;
        csa3.cry = ((a & b) | (a & c) | (b & c)) << 1;
    endfunction

    // Sum of the negative weights that replace per-row sign extension
    function automatic acc_t sign_const();
        acc_t k = '0;
        for (int j = 0; j < NPP; j++)
            k = k - (acc_t'(1) << (PPW - 1 + 2 * j));
        return k;
    endfunction

    localparam acc_t SIGN_K = sign_const();

endpackage

// File: rtl/mac_booth_stage.sv
module mac_booth_stage
    import mac_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_clear,
    input  logic [OPW-1:0]          in_x,
    input  logic [OPW-1:0]          in_y,
    output pp_row_t [NPP-1:0]       rows,
    output logic                    s1_valid,
    output logic                    s1_clear
);

    logic [OPW:0]     x_ext;
    pp_row_t [NPP-1:0] rows_d;

    assign x_ext = {in_x, 1'b0};

    for (genvar j = 0; j < NPP; j++) begin : g_row
        assign rows_d[j] = make_row(recode(x_ext[2*j+2 : 2*j]), in_y);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rows     <= '0;
            s1_valid <= 1'b0;
            s1_clear <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            s1_clear <= in_clear;
            if (in_valid)
                rows <= rows_d;
        end
    end

endmodule

// File: rtl/mac_csa_accum.sv
module mac_csa_accum
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pp_row_t [NPP-1:0] rows,
    input  logic              s1_valid,
    input  logic              s1_clear,
    output logic [UPW-1:0]    acc_sum_hi,
    output logic [UPW-1:0]    acc_cry_hi,
    output logic              acc_cy,
    output logic [LOWW-1:0]   acc_low,
    output logic              s2_valid
);

    acc_t            opnd [NPP];
    acc_t            corr;
    acc_t            fb_sum, fb_cry, fb_cy;
    csa_t            l1a, l1b, l2a, l2b, l3, l4;
    logic [LOWW-1:0] g_lo, p_lo, z_lo;
    logic [LOWW:0]   c_lo;

    // Rows placed at their digit weight, top bit flipped for the sign constant
    for (genvar j = 0; j < NPP; j++) begin : g_place
        assign opnd[j] = acc_t'({~rows[j].bits[PPW-1], rows[j].bits[PPW-2:0]}) << (2 * j);
    end

    always_comb begin
        corr = SIGN_K;
        for (int j = 0; j < NPP; j++)
            corr[2*j] = rows[j].neg;
    end

    // Feedback of the redundant total; a clear replaces it with zero
    assign fb_sum = s1_clear ? '0 : {acc_sum_hi, acc_low};
    assign fb_cry = s1_clear ? '0 : {acc_cry_hi, {LOWW{1'b0}}};
    assign fb_cy  = s1_clear ? '0 : (acc_t'(acc_cy) << LOWW);

    // Four levels of 3:2 compression over eight operands
    assign l1a = csa3(opnd[0], opnd[1], opnd[2]);
    assign l1b = csa3(opnd[3], corr, fb_sum);
    assign l2a = csa3(l1a.sum, l1a.cry, l1b.sum);
    assign l2b = csa3(l1b.cry, fb_cry, fb_cy);
    assign l3  = csa3(l2a.sum, l2a.cry, l2b.sum);
    assign l4  = csa3(l3.sum, l3.cry, l2b.cry);

    // Early lookahead resolution of the lowest bits
    assign g_lo    = l4.sum[LOWW-1:0] & l4.cry[LOWW-1:0];
    assign p_lo    = l4.sum[LOWW-1:0] ^ l4.cry[LOWW-1:0];
    assign c_lo[0] = 1'b0;
    assign c_lo[1] = g_lo[0] | (p_lo[0] & c_lo[0]);
    assign c_lo[2] = g_lo[1] | (p_lo[1] & g_lo[0]) | (p_lo[1] & p_lo[0] & c_lo[0]);
    assign z_lo    = p_lo ^ c_lo[LOWW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_sum_hi <= '0;
            acc_cry_hi <= '0;
            acc_cy     <= 1'b0;
            acc_low    <= '0;
            s2_valid   <= 1'b0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                acc_sum_hi <= l4.sum[ACCW-1:LOWW];
                acc_cry_hi <= l4.cry[ACCW-1:LOWW];
                acc_cy     <= c_lo[LOWW];
                acc_low    <= z_lo;
            end else if (s1_clear) begin
                acc_sum_hi <= '0;
                acc_cry_hi <= '0;
                acc_cy     <= 1'b0;
                acc_low    <= '0;
            end
        end
    end

endmodule

// File: rtl/mac_final_add.sv
module mac_final_add
    import mac_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            s2_valid,
    input  logic [UPW-1:0]  acc_sum_hi,
    input  logic [UPW-1:0]  acc_cry_hi,
    input  logic            acc_cy,
    input  logic [LOWW-1:0] acc_low,
    output logic            out_valid,
    output acc_t            out_acc
);

    logic [UPW-1:0] upper;

    assign upper = acc_sum_hi + acc_cry_hi + UPW'(acc_cy);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_acc   <= '0;
        end else begin
            out_valid <= s2_valid;
            if (s2_valid)
                out_acc <= {upper, acc_low};
        end
    end

endmodule

// File: rtl/booth_mac_csa.sv
module booth_mac_csa
    import mac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_clear,
    input  logic [7:0]       in_x,
    input  logic [7:0]       in_y,
    output logic             out_valid,
    output logic [19:0]      out_acc
);

    pp_row_t [NPP-1:0] rows;
    logic              s1_valid, s1_clear, s2_valid;
    logic [UPW-1:0]    acc_sum_hi, acc_cry_hi;
    logic              acc_cy;
    logic [LOWW-1:0]   acc_low;

    mac_booth_stage u_booth (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_clear (in_clear),
        .in_x     (in_x),
        .in_y     (in_y),
        .rows     (rows),
        .s1_valid (s1_valid),
        .s1_clear (s1_clear)
    );

    mac_csa_accum u_accum (
        .clk        (clk),
        .rst        (rst),
        .rows       (rows),
        .s1_valid   (s1_valid),
        .s1_clear   (s1_clear),
        .acc_sum_hi (acc_sum_hi),
        .acc_cry_hi (acc_cry_hi),
        .acc_cy     (acc_cy),
        .acc_low    (acc_low),
        .s2_valid   (s2_valid)
    );

    mac_final_add u_final (
        .clk        (clk),
        .rst        (rst),
        .s2_valid   (s2_valid),
        .acc_sum_hi (acc_sum_hi),
        .acc_cry_hi (acc_cry_hi),
        .acc_cy     (acc_cy),
        .acc_low    (acc_low),
        .out_valid  (out_valid),
        .out_acc    (out_acc)
    );

endmodule

// File: rtl/mac_checker.sv
module mac_checker
    import mac_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_clear,
    input logic signed [7:0]   in_x,
    input logic signed [7:0]   in_y,
    input logic                out_valid,
    input logic [19:0]         out_acc,
    input logic                s1_valid,
    input logic                s1_clear,
    input logic [UPW-1:0]      acc_sum_hi,
    input logic [UPW-1:0]      acc_cry_hi,
    input logic                acc_cy,
    input logic [LOWW-1:0]     acc_low
);

    logic [1:0] warm;

    always_ff @(posedge clk) begin
        if (rst)
            warm <= '0;
        else if (warm != 2'd3)
            warm <= warm + 2'd1;
    end

    function automatic acc_t wide_prod(input logic signed [7:0] a, input logic signed [7:0] b);
        logic signed [15:0] p;
        p = a * b;
        return {{GUARD{p[15]}}, p};
    endfunction

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (warm != 2'd0 && !out_valid) |-> $stable(out_acc));

    // R4
    state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!s1_valid && !s1_clear) |=> $stable({acc_sum_hi, acc_cry_hi, acc_cy, acc_low}));

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_clear && !s1_valid) |=>
            (acc_sum_hi == '0 && acc_cry_hi == '0 && !acc_cy && acc_low == '0));

    // R5
    restart_prod_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && out_valid && $past(in_valid && in_clear, 3)) |->
            (out_acc == wide_prod($past(in_x, 3), $past(in_y, 3))));

endmodule

bind booth_mac_csa mac_checker u_mac_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_clear   (in_clear),
    .in_x       (in_x),
    .in_y       (in_y),
    .out_valid  (out_valid),
    .out_acc    (out_acc),
    .s1_valid   (s1_valid),
    .s1_clear   (s1_clear),
    .acc_sum_hi (acc_sum_hi),
    .acc_cry_hi (acc_cry_hi),
    .acc_cy     (acc_cy),
    .acc_low    (acc_low)
);

// File: tb/test_booth_mac_csa.sv
module test_booth_mac_csa;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_clear = 1'b0;
    logic [7:0]  in_x = '0;
    logic [7:0]  in_y = '0;
    logic        out_valid;
    logic [19:0] out_acc;

    booth_mac_csa i_booth_mac_csa (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_clear  (in_clear),
        .in_x      (in_x),
        .in_y      (in_y),
        .out_valid (out_valid),
        .out_acc   (out_acc)
    );

    always #4 clk = ~clk; // 125 MHz

    int          cyc = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [19:0] ref_acc = '0;

    int          exp_due [0:1023];
    logic [19:0] exp_val [0:1023];
    string       exp_req [0:1023];
    int          head = 0;
    int          tail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [19:0] act, input logic [19:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Result monitor: each expectation is due in exactly one cycle (R3)
    always @(negedge clk) begin
        if (!rst) begin
            if (head < tail && exp_due[head] == cyc) begin
                check(out_valid == 1'b1, "R3 out_valid missing", {19'd0, out_valid}, 20'd1);
                check(out_acc == exp_val[head], exp_req[head], out_acc, exp_val[head]);
                head++;
            end else if (out_valid) begin
                check(1'b0, "R3 unexpected result", out_acc, 20'd0);
            end
        end
    end

    function automatic logic [19:0] prod20(input logic signed [7:0] a, input logic signed [7:0] b);
        logic signed [15:0] p;
        p = a * b;
        return {{4{p[15]}}, p};
    endfunction

    // Drive one sample at the current falling edge and expect its result
    task automatic send(input logic [7:0] x, input logic [7:0] y, input bit clr, input string req);
        in_valid = 1'b1;
        in_clear = clr;
        in_x     = x;
        in_y     = y;
        ref_acc  = clr ? prod20(x, y) : ref_acc + prod20(x, y);
        exp_due[tail] = cyc + 3;
        exp_val[tail] = ref_acc;
        exp_req[tail] = req;
        tail++;
        @(negedge clk);
        in_valid = 1'b0;
        in_clear = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        in_clear = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input string req);
        idle(5);
        check(head == tail, req, 20'(tail - head), 20'd0);
    endtask

    task automatic t_reset();
        check(out_valid == 1'b0, "R1 out_valid after reset", {19'd0, out_valid}, 20'd0);
        check(out_acc == 20'd0, "R1 out_acc after reset", out_acc, 20'd0);
        ref_acc = '0;
        send(8'sd3, 8'sd5, 1'b0, "R1 first sample without clear");
        drain("R1 drain");
    endtask

    task automatic t_stream();
        send(8'sd7, -8'sd9, 1'b0, "R2 mixed signs");
        send(-8'sd33, -8'sd44, 1'b0, "R2 both negative");
        send(8'sd100, 8'sd3, 1'b0, "R2 positive");
        send(8'sd85, -8'sd86, 1'b0, "R2 alternating bits");
        send(-8'sd1, 8'sd1, 1'b0, "R3 back-to-back");
        drain("R3 stream drain");
    endtask

    task automatic t_gaps();
        logic [19:0] held;
        send(8'sd12, 8'sd11, 1'b0, "R4 before gap");
        idle(4);
        held = out_acc;
        for (int i = 0; i < 4; i++) begin
            check(out_valid == 1'b0, "R4 no result while idle", {19'd0, out_valid}, 20'd0);
            check(out_acc == held, "R4 result holds while idle", out_acc, held);
            @(negedge clk);
        end
        send(-8'sd5, 8'sd6, 1'b0, "R4 total kept across gap");
        drain("R4 drain");
    endtask

    task automatic t_clear_load();
        send(8'sd20, 8'sd20, 1'b0, "R5 build total");
        send(-8'sd3, 8'sd7, 1'b1, "R5 clear with valid");
        send(8'sd2, 8'sd2, 1'b0, "R5 continue after restart");
        drain("R5 drain");
    endtask

    task automatic t_clear_only();
        send(8'sd50, 8'sd50, 1'b0, "R6 build total");
        in_valid = 1'b0;
        in_clear = 1'b1;
        ref_acc  = '0;
        @(negedge clk);
        in_clear = 1'b0;
        idle(4);
        send(-8'sd9, -8'sd9, 1'b0, "R6 product alone after clear");
        drain("R6 drain");
    endtask

    task automatic t_extremes();
        send(8'h80, 8'h80, 1'b1, "R7 -128*-128");
        check(ref_acc == 20'd16384, "R7 ref -128*-128", ref_acc, 20'd16384);
        send(8'h80, 8'h7f, 1'b1, "R7 -128*127");
        check(ref_acc == 20'hFC080, "R7 ref -128*127", ref_acc, 20'hFC080);
        send(8'h7f, 8'h80, 1'b1, "R7 127*-128");
        send(8'h7f, 8'h7f, 1'b1, "R7 127*127");
        drain("R7 drain");
    endtask

    task automatic t_zeros();
        send(8'sd0, -8'sd77, 1'b0, "R9 zero multiplier");
        send(8'h80, 8'sd0, 1'b0, "R9 zero multiplicand");
        send(8'sd0, 8'sd0, 1'b0, "R9 both zero");
        drain("R9 drain");
    endtask

    task automatic t_wrap();
        send(8'h80, 8'h80, 1'b1, "R8 run start");
        for (int i = 1; i < 40; i++) begin
            send(8'h80, 8'h80, 1'b0, "R8 long run");
            if (i == 15)
                check(ref_acc == 20'd262144, "R8 16 accumulations exact", ref_acc, 20'd262144);
            if (i == 31)
                check(ref_acc == 20'h80000, "R8 wrap after 32", ref_acc, 20'h80000);
        end
        drain("R8 drain");
    endtask

    task automatic t_sweep();
        logic [31:0] st = 32'h1234_5678;
        for (int i = 0; i < 300; i++) begin
            st = st ^ (st << 13);
            st = st ^ (st >> 17);
            st = st ^ (st << 5);
            if (st[20:18] == 3'd0) begin
                idle(1);
            end else begin
                send(st[7:0], st[15:8], st[25:22] == 4'd0, "R2 sweep");
            end
        end
        drain("R2 sweep drain");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_stream();
        t_gaps();
        t_clear_load();
        t_clear_only();
        t_extremes();
        t_zeros();
        t_wrap();
        t_sweep();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule